// File: doc/BRIEF.md
# Sub-Source Interrupt Aggregator

This block gathers eleven peripheral sub-interrupts into one pending register and drives four level requests into the core interrupt controller. Three serial ports each contribute three sources: receive, transmit and error. The analog section contributes two: touch and conversion done. A one-cycle pulse on a source input latches that source's pending bit. The bit stays set until software writes a one to it.

A companion mask register has one bit per source. A masked source stays pending but is kept off its parent line. Each parent request is the OR of the unmasked pending bits in its group. Software reaches both registers through a single-cycle write port and a combinational read port. A select input picks the register for both reads and writes.

Top module: `subirq_agg`

## Requirements
- R1: After reset, every pending bit reads 0, every mask bit reads 1 (0x7FF), and all four parent outputs are 0.
- R2: A 1 on `src_set_i[b]` sets pending bit b at the next clock edge, whatever the value of mask bit b.
- R3: A write with `reg_sel_i`=0 clears each pending bit whose `wdata_i` bit is 1. Pending bits whose `wdata_i` bit is 0 keep their value.
- R4: A write with `reg_sel_i`=1 loads all eleven mask bits from `wdata_i`. The pending bits do not change. With `reg_sel_i`=1, `rdata_o` returns the mask register; with `reg_sel_i`=0 it returns the pending register.
- R5: `parent_o[k]`, for k = 0, 1, 2, is 1 exactly when at least one of pending bits 3k (receive), 3k+1 (transmit) or 3k+2 (error) is set with its mask bit 0.
- R6: `parent_o[3]` is 1 exactly when pending bit 9 (touch) or pending bit 10 (conversion done) is set with its mask bit 0.
- R7: If a set pulse and a clearing write reach the same pending bit in the same cycle, the bit ends up set.
- R8: Masking never changes pending contents. Clearing a mask bit whose pending bit is already set raises that group's parent with no new pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_set_i | input | 11 | Per-source set pulses, bit layout as in R5/R6 |
| wr_en_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects pending register, 1 selects mask register |
| wdata_i | input | 11 | Write data (clear bits or new mask) |
| rdata_o | output | 11 | Selected register contents |
| parent_o | output | 4 | Level requests: bits 0-2 serial ports 0-2, bit 3 analog |

## Verification
Each source is set in turn while every mask bit is 1. This shows that pending capture is independent of the mask, and that a masked source cannot reach a parent. Unmasking one bit at a time, with a single source pending, checks the bit-to-group mapping: a wrong group boundary lights the wrong parent. Clear writes mixing ones and zeros test the write-one-to-clear rule. Writes that land in the same cycle as a set pulse test the priority rule. A long random mix of pulses, clears and mask writes, checked against a reference model, covers group overlaps that the directed cases miss.

// File: rtl/subirq_pkg.sv
package subirq_pkg;
  localparam int unsigned UART_CNT = 3;
  localparam int unsigned UART_SRC = 3;
  localparam int unsigned ADC_SRC  = 2;

  typedef enum logic {
    REG_PEND = 1'b0,
    REG_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/subirq_pend.sv
module subirq_pend #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;

  // set has priority over clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/subirq_mask.sv
module subirq_mask #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '1;
    else if (wr_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/subirq_group.sv
module subirq_group #(
  parameter int unsigned UART_CNT = 3,
  parameter int unsigned UART_SRC = 3,
  parameter int unsigned ADC_SRC  = 2,
  localparam int unsigned W   = UART_CNT * UART_SRC + ADC_SRC,
  localparam int unsigned PW  = UART_CNT + 1,
  localparam int unsigned ADC_LSB = UART_CNT * UART_SRC
) (
  input  logic [W-1:0]  pend_i,
  input  logic [W-1:0]  mask_i,
  output logic [PW-1:0] parent_o
);
  logic [W-1:0] live;
  assign live = pend_i & ~mask_i;

  for (genvar g = 0; g < UART_CNT; g++) begin : g_uart
    assign parent_o[g] = |live[g*UART_SRC +: UART_SRC];
  end

  assign parent_o[UART_CNT] = |live[ADC_LSB +: ADC_SRC];
endmodule

// File: rtl/subirq_agg.sv
module subirq_agg
  import subirq_pkg::*;
#(
  parameter int unsigned N_UART = UART_CNT,
  parameter int unsigned N_USRC = UART_SRC,
  parameter int unsigned N_ASRC = ADC_SRC,
  localparam int unsigned W  = N_UART * N_USRC + N_ASRC,
  localparam int unsigned PW = N_UART + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  src_set_i,
  input  logic          wr_en_i,
  input  logic          reg_sel_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [PW-1:0] parent_o
);
  reg_sel_e     sel;
  logic [W-1:0] pend_q, mask_q, clr;
  logic         mask_wr;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign clr     = (wr_en_i && sel == REG_PEND) ? wdata_i : '0;
  assign mask_wr = wr_en_i && sel == REG_MASK;

  subirq_pend #(.W(W)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (src_set_i),
    .clr_i  (clr),
    .pend_o (pend_q)
  );

  subirq_mask #(.W(W)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (mask_wr),
    .wdata_i (wdata_i),
    .mask_o  (mask_q)
  );

  subirq_group #(
    .UART_CNT (N_UART),
    .UART_SRC (N_USRC),
    .ADC_SRC  (N_ASRC)
  ) u_group (
    .pend_i   (pend_q),
    .mask_i   (mask_q),
    .parent_o (parent_o)
  );

  assign rdata_o = (sel == REG_MASK) ? mask_q : pend_q;
endmodule

// File: rtl/subirq_agg_chk.sv
module subirq_agg_chk #(
  parameter int unsigned N_UART = 3,
  parameter int unsigned N_USRC = 3,
  parameter int unsigned N_ASRC = 2,
  localparam int unsigned W  = N_UART * N_USRC + N_ASRC,
  localparam int unsigned PW = N_UART + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [W-1:0]  src_set_i,
  input logic          wr_en_i,
  input logic          reg_sel_i,
  input logic [W-1:0]  wdata_i,
  input logic [W-1:0]  pend_q,
  input logic [W-1:0]  mask_q,
  input logic [PW-1:0] parent_o
);
  logic [W-1:0] live;
  assign live = pend_q & ~mask_q;

  assert_reset_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pend_q == '0 && mask_q == '1 && parent_o == '0));

  assert_set_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_set_i) |=> ((pend_q & $past(src_set_i)) == $past(src_set_i)));

  assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !reg_sel_i) |=> ((pend_q & $past(wdata_i & ~src_set_i)) == '0));

  assert_mask_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_sel_i) |=> (mask_q == $past(wdata_i)));

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !reg_sel_i && |(wdata_i & src_set_i))
      |=> ((pend_q & $past(wdata_i & src_set_i)) == $past(wdata_i & src_set_i)));

  assert_no_spurious_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(rst_ni) |-> ((pend_q & ~$past(pend_q) & ~$past(src_set_i)) == '0));

  for (genvar g = 0; g < N_UART; g++) begin : g_par
    assert_uart_parent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      parent_o[g] == (|live[g*N_USRC +: N_USRC]));
  end

  assert_adc_parent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parent_o[N_UART] == (|live[N_UART*N_USRC +: N_ASRC]));
endmodule

bind subirq_agg subirq_agg_chk #(
  .N_UART (N_UART),
  .N_USRC (N_USRC),
  .N_ASRC (N_ASRC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_set_i (src_set_i),
  .wr_en_i   (wr_en_i),
  .reg_sel_i (reg_sel_i),
  .wdata_i   (wdata_i),
  .pend_q    (pend_q),
  .mask_q    (mask_q),
  .parent_o  (parent_o)
);

// File: tb/subirq_agg_test.sv
`timescale 1ns/100ps
module subirq_agg_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] src_set_i = '0;
  logic        wr_en_i = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic [10:0] wdata_i = '0;
  logic [10:0] rdata_o;
  logic [3:0]  parent_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [10:0] exp_pend, exp_mask;

  always #2 clk_i = ~clk_i;

  subirq_agg uut (.*);

  function automatic logic [3:0] exp_par(logic [10:0] p, logic [10:0] m);
    logic [10:0] a;
    a = p & ~m;
    return {|a[10:9], |a[8:6], |a[5:3], |a[2:0]};
  endfunction

  task automatic chk(string tag, string what, logic [10:0] act, logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%03h expected=%03h", tag, what, act, exp);
    end
  endtask

  // called at negedge: compare all observable state with the model
  task automatic check_all(string tag);
    chk(tag, "parent", {7'd0, parent_o}, {7'd0, exp_par(exp_pend, exp_mask)});
    reg_sel_i = 1'b0; #0.4;
    chk(tag, "pending", rdata_o, exp_pend);
    reg_sel_i = 1'b1; #0.4;
    chk(tag, "mask", rdata_o, exp_mask);
  endtask

  // drive one cycle of stimulus at negedge, update model at posedge
  task automatic cyc(logic [10:0] set, logic wr, logic sel, logic [10:0] wd);
    src_set_i = set; wr_en_i = wr; reg_sel_i = sel; wdata_i = wd;
    @(posedge clk_i);
    exp_pend = (exp_pend & ~((wr && !sel) ? wd : 11'd0)) | set;
    if (wr && sel) exp_mask = wd;
    @(negedge clk_i);
    src_set_i = '0; wr_en_i = 1'b0; wdata_i = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    exp_pend = '0; exp_mask = '1;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1");

    // R2/R8: each source sets while fully masked; parent must stay low
    for (int b = 0; b < 11; b++) begin
      cyc(11'd1 << b, 1'b0, 1'b0, '0);
      check_all("R2");
    end
    cyc('0, 1'b1, 1'b0, '1);
    check_all("R3");

    // R5/R6: single pending source, unmask one bit at a time
    for (int b = 0; b < 11; b++) begin
      cyc(11'd1 << b, 1'b1, 1'b1, ~(11'd1 << b));
      check_all(b < 9 ? "R5" : "R6");
      cyc('0, 1'b1, 1'b1, '1);
      cyc('0, 1'b1, 1'b0, 11'd1 << b);
    end

    // R8: pending survives mask, unmask later raises parent
    cyc(11'h210, 1'b0, 1'b0, '0);
    check_all("R8");
    cyc('0, 1'b1, 1'b1, 11'h5EF);
    check_all("R8");

    // R4: mask pattern readback, pending unchanged
    cyc('0, 1'b1, 1'b1, 11'h2AA);
    check_all("R4");
    cyc('0, 1'b1, 1'b1, 11'h555);
    check_all("R4");

    // R3: partial clear keeps zero-written bits
    cyc(11'h7FF, 1'b0, 1'b0, '0);
    cyc('0, 1'b1, 1'b0, 11'h0F0);
    check_all("R3");

    // R7: set and clear collide on same bits
    cyc(11'h401, 1'b1, 1'b0, 11'h7FF);
    check_all("R7");
    cyc(11'h400, 1'b1, 1'b0, 11'h400);
    check_all("R7");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [10:0] s;
      s = 11'($urandom) & 11'($urandom) & 11'($urandom);
      cyc(s, 1'($urandom), 1'($urandom), 11'($urandom));
      check_all("R5");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule